// File: doc/BRIEF.md
# Card Slot Status and Insertion Interrupt Registers

This block is a small word-addressed register bank that sits beside a removable-card slot. It reports the present state of the slot's write-protect switch as a live level, and it remembers that a card was inserted, holding an interrupt request until software acknowledges the event. Two further words return fixed constants, one as an identification value and one as a decode value. A flash-programming word is present only as a placeholder that reads zero.

Both slot inputs are asynchronous to the bus clock and pass through a synchronizer chain before anything uses them. The insertion flag is sticky. Only the synchronized insertion level sets it, and only a software write with the acknowledge bit set clears it. The flag does not fall when the insertion input drops. The interrupt output is the flag itself.

Top module: `slot_status_regs`

## Requirements
- R1: Word 0 reads 0x41034003 and writes to it have no effect.
- R2: Word 1 reads 0 and writes to it have no effect.
- R3: Word 3 reads 0x11 and writes to it have no effect.
- R4: Bit 0 of word 2 reads the write-protect input after a two-stage synchronizer. It first shows a new level on the read made after the second rising edge following the change. Bits of word 2 other than 0 and 3 read 0.
- R5: While the synchronized card-insert level is 1, bit 3 of word 2 (the insertion flag) is set. It first reads 1 after the third rising edge following the input rising. A one-cycle input pulse is captured.
- R6: When the card-insert input falls, the insertion flag and the interrupt keep their value.
- R7: A write to word 2 with data bit 3 = 1 clears the insertion flag. A write with data bit 3 = 0 leaves it unchanged. No write changes bit 0.
- R8: The interrupt output always equals the insertion flag as read in bit 3 of word 2.
- R9: If the synchronized card-insert level is 1 on the edge of an acknowledge write, the flag stays set.
- R10: Reads of words 4 and above return 0, and writes to them change no readable state.
- R11: After reset, word 2 reads 0 and the interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_level_i | input | 1 | Write-protect switch level, asynchronous |
| card_ins_i | input | 1 | Card-insert indication, asynchronous, active high |
| bus_en_i | input | 1 | Access strobe for one cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (4) | Word address |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data, combinational, 0 when not reading |
| slot_irq_o | output | 1 | Card-insertion interrupt request |

## Verification
The constant, placeholder and unmapped words are driven with writes of all-ones and all-zeros and then read back. This separates true read-only decode from any accidental storage. The insertion input is tried as a long level, as a falling edge after the flag is set, and as a single-cycle pulse, which tells a sticky latch apart from a level follower and from an edge detector that misses short events. Acknowledge writes are made with bit 3 clear and other bits set, with bit 3 set while the input is low, and with bit 3 set while the synchronized input is still high. These cases separate the write mask, the clear path and the set-over-clear priority. Reads sampled one cycle before and on the expected cycle pin down the synchronizer depth.

// File: rtl/slot_pkg.sv
package slot_pkg;
   // word offsets decoded by the register block
   localparam int unsigned WORD_ID    = 0;
   localparam int unsigned WORD_FLASH = 1;
   localparam int unsigned WORD_STAT  = 2;
   localparam int unsigned WORD_DEC   = 3;
   // bit positions inside the status word
   localparam int unsigned WP_POS  = 0;
   localparam int unsigned INS_POS = 3;
endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("slot_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("slot_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/slot_event_latch.sv
module slot_event_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   // R5 R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);
   // R7
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_q);
   // R6
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(flag_q));
endmodule

// File: rtl/slot_status_regs.sv
module slot_status_regs
   import slot_pkg::*;
#(
   parameter int unsigned ADDR_W       = 4,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter logic [DATA_W-1:0] ID_VALUE     = 32'h4103_4003,
   parameter logic [DATA_W-1:0] DECODE_VALUE = 32'h0000_0011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_level_i,
   input  logic              card_ins_i,
   input  logic              bus_en_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              slot_irq_o
);
   localparam int unsigned NWORDS = 1 << ADDR_W;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("slot_status_regs: ADDR_W too small to decode four words");
      end
      if (DATA_W <= INS_POS) begin : g_bad_data
         $error("slot_status_regs: DATA_W must hold the insertion bit");
      end
      if (NWORDS <= WORD_DEC) begin : g_bad_words
         $error("slot_status_regs: address space smaller than the map");
      end
   endgenerate

   logic [1:0]        raw_in;
   logic [1:0]        sync_in;
   logic              wp_s;
   logic              ins_s;
   logic              ack_wr;
   logic              ins_flag;
   logic              rd_strobe;
   logic [DATA_W-1:0] stat_word;

   assign raw_in = {card_ins_i, wp_level_i};

   slot_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (sync_in)
   );

   assign wp_s  = sync_in[0];
   assign ins_s = sync_in[1];

   assign ack_wr = bus_en_i && bus_we_i
                   && (bus_addr_i == ADDR_W'(WORD_STAT))
                   && bus_wdata_i[INS_POS];

   slot_event_latch u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (ins_s),
      .clr_i  (ack_wr),
      .flag_o (ins_flag)
   );

   assign slot_irq_o = ins_flag;

   always_comb begin
      stat_word          = '0;
      stat_word[WP_POS]  = wp_s;
      stat_word[INS_POS] = ins_flag;
   end

   assign rd_strobe = bus_en_i && !bus_we_i;

   always_comb begin
      bus_rdata_o = '0;
      if (rd_strobe) begin
         case (bus_addr_i)
            ADDR_W'(WORD_ID):    bus_rdata_o = ID_VALUE;
            ADDR_W'(WORD_FLASH): bus_rdata_o = '0;
            ADDR_W'(WORD_STAT):  bus_rdata_o = stat_word;
            ADDR_W'(WORD_DEC):   bus_rdata_o = DECODE_VALUE;
            default:             bus_rdata_o = '0;
         endcase
      end
   end

   // R8
   irq_matches_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && bus_addr_i == ADDR_W'(WORD_STAT))
         |-> (bus_rdata_o[INS_POS] == slot_irq_o));
   // R5
   irq_needs_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slot_irq_o) |-> $past(ins_s));
   // R10
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && bus_addr_i > ADDR_W'(WORD_DEC)) |-> (bus_rdata_o == '0));
   // R1
   id_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && bus_addr_i == ADDR_W'(WORD_ID)) |-> (bus_rdata_o == ID_VALUE));
endmodule

// File: tb/slot_status_regs_bench.sv
module slot_status_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wp_level_i = 1'b0;
   logic        card_ins_i = 1'b0;
   logic        bus_en_i = 1'b0;
   logic        bus_we_i = 1'b0;
   logic [3:0]  bus_addr_i = '0;
   logic [31:0] bus_wdata_i = '0;
   logic [31:0] bus_rdata_o;
   logic        slot_irq_o;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   slot_status_regs u_slot_status_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wp_level_i  (wp_level_i),
      .card_ins_i  (card_ins_i),
      .bus_en_i    (bus_en_i),
      .bus_we_i    (bus_we_i),
      .bus_addr_i  (bus_addr_i),
      .bus_wdata_i (bus_wdata_i),
      .bus_rdata_o (bus_rdata_o),
      .slot_irq_o  (slot_irq_o)
   );

   // vector: {write, addr, wdata, expected read}
   localparam int NV = 13;
   localparam logic [68:0] VEC [NV] = '{
      {1'b0, 4'd0,  32'h0,         32'h4103_4003},
      {1'b0, 4'd1,  32'h0,         32'h0},
      {1'b0, 4'd3,  32'h0,         32'h11},
      {1'b1, 4'd1,  32'hFFFF_FFFF, 32'h0},
      {1'b0, 4'd1,  32'h0,         32'h0},
      {1'b1, 4'd3,  32'hFFFF_FFFF, 32'h0},
      {1'b0, 4'd3,  32'h0,         32'h11},
      {1'b1, 4'd0,  32'h0,         32'h0},
      {1'b0, 4'd0,  32'h0,         32'h4103_4003},
      {1'b0, 4'd4,  32'h0,         32'h0},
      {1'b1, 4'd9,  32'hFFFF_FFFF, 32'h0},
      {1'b0, 4'd9,  32'h0,         32'h0},
      {1'b0, 4'd15, 32'h0,         32'h0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      bus_en_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
      tick();
      bus_en_i = 1'b0; bus_we_i = 1'b0; bus_wdata_i = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      bus_en_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
      #1;
      d = bus_rdata_o;
      bus_en_i = 1'b0;
   endtask

   function automatic string tag_of(input logic [3:0] a);
      case (a)
         4'd0:    return "R1";
         4'd1:    return "R2";
         4'd3:    return "R3";
         default: return "R10";
      endcase
   endfunction

   initial begin
      logic [31:0] r;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R11 reset state
      rd(4'd2, r);
      chk("R11 status after reset", r, 32'h0);
      chk("R11 irq after reset", {31'b0, slot_irq_o}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][68]) wr(VEC[i][67:64], VEC[i][63:32]);
         else begin
            rd(VEC[i][67:64], r);
            chk(tag_of(VEC[i][67:64]), r, VEC[i][31:0]);
         end
      end

      // R4 write-protect through two stages
      wp_level_i = 1'b1;
      tick();
      rd(4'd2, r);
      chk("R4 wp not yet visible", r, 32'h0);
      tick();
      rd(4'd2, r);
      chk("R4 wp visible", r, 32'h1);

      // R5 insertion after three edges
      card_ins_i = 1'b1;
      tick(); tick();
      rd(4'd2, r);
      chk("R5 flag not yet set", r, 32'h1);
      tick();
      rd(4'd2, r);
      chk("R5 flag set", r, 32'h9);
      chk("R8 irq with flag", {31'b0, slot_irq_o}, 32'h1);

      // R6 input falls, flag holds
      card_ins_i = 1'b0;
      repeat (3) tick();
      rd(4'd2, r);
      chk("R6 flag held", r, 32'h9);
      chk("R6 irq held", {31'b0, slot_irq_o}, 32'h1);

      // R7 write without bit 3 leaves flag and wp
      wr(4'd2, 32'hFFFF_FFF7);
      rd(4'd2, r);
      chk("R7 no ack bit", r, 32'h9);
      wr(4'd2, 32'h0000_0008);
      rd(4'd2, r);
      chk("R7 ack clears, wp kept", r, 32'h1);
      chk("R8 irq cleared", {31'b0, slot_irq_o}, 32'h0);

      // R9 set beats clear
      card_ins_i = 1'b1;
      repeat (3) tick();
      wr(4'd2, 32'h0000_0008);
      rd(4'd2, r);
      chk("R9 set wins over ack", r, 32'h9);
      chk("R9 irq stays", {31'b0, slot_irq_o}, 32'h1);
      card_ins_i = 1'b0;
      tick(); tick();
      wr(4'd2, 32'h0000_0008);
      rd(4'd2, r);
      chk("R9 ack after input low", r, 32'h1);

      // R4 wp falls
      wp_level_i = 1'b0;
      tick(); tick();
      rd(4'd2, r);
      chk("R4 wp low", r, 32'h0);

      // R5 single-cycle pulse captured
      card_ins_i = 1'b1;
      tick();
      card_ins_i = 1'b0;
      repeat (3) tick();
      rd(4'd2, r);
      chk("R5 pulse latched", r, 32'h8);

      // R10 unmapped write leaves flag
      wr(4'd5, 32'hFFFF_FFFF);
      rd(4'd2, r);
      chk("R10 unmapped write ignored", r, 32'h8);
      chk("R8 irq after unmapped write", {31'b0, slot_irq_o}, 32'h1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h0, 32'h1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule